// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Bypass

This block sits between a write-through data cache and the lower memory level. Every processor store is posted into a small queue so that the processor keeps running, and the queue empties itself toward memory in arrival order over a single valid/ready request port. Each queued slot carries a word address, a data word and one enable bit per byte lane. The lane numbering is fixed: lane i is data bits 8i+7..8i and is controlled by enable bit i.

Cache read misses also go to memory through this block. A read does not wait for the queue to empty. Before anything goes out, the read address is compared against every queued slot. Bytes that are held in the queue are taken from the newest slot that writes them. When all four lanes are covered, the read is answered locally. Otherwise the read goes to memory ahead of any queued write that has not yet been offered to the port. The bytes that memory returns fill only the lanes the queue did not supply.

A store to a word that already has a queued slot, where that slot has not yet been offered to memory, is folded into that slot. When all slots are in use, a store that cannot be folded raises a stall until a slot drains. A stall is not raised when a drain completes in the same cycle.

Top module: `wt_store_buffer`

## Requirements
- R1: Every accepted store reaches memory as a write request (mem_req_write=1) with its address, data and byte enables. Writes leave in the order the stores were accepted, one request per queue slot.
- R2: The queue holds 4 slots. A store is accepted at a clock edge when st_valid=1 and st_stall=0. st_stall is 1 only while all 4 slots are occupied, the store cannot be folded and no write is accepted by memory in that cycle.
- R3: When the queue is full and memory accepts the head write in the same cycle as a new store arrives, st_stall stays 0 and the store takes the freed slot.
- R4: A read not fully covered by queued bytes is sent as a request with mem_req_write=0 and mem_req_be=4'b1111. It goes out before every queued write that has not yet been offered to memory. A write already being offered completes first.
- R5: A read whose four lanes are all covered by queued stores is answered with rd_done=1 in the cycle after rd_valid is taken, and sends no request to memory.
- R6: When several queued slots write the same lane of the read word, the read returns the byte from the most recently accepted of them.
- R7: On a partly covered read, lanes held in the queue come from the queue and the remaining lanes come from the memory response (lane i = bits 8i+7..8i, enable bit i).
- R8: A store to the same word (address bits 31..2) as a queued slot that has not been offered to memory is merged into that slot. Its enabled lanes overwrite the slot's lanes, and the enables are ORed. Memory then sees one write for both stores.
- R9: Once a request is offered with mem_req_ready=0, mem_req_valid stays 1 and the write flag, address, data and enables stay unchanged until the request is accepted.
- R10: A synchronous active-low reset discards all queued slots and returns the read path to idle. After reset no request is offered, st_stall=0, rd_done=0, and a later read to a discarded address is served from memory.
- R11: rd_done is a single-cycle pulse for each read. rd_data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_addr | input | 32 | Store byte address (word granular) |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte-lane enables |
| st_stall | output | 1 | Store cannot be taken this cycle |
| rd_valid | input | 1 | Read miss request, held until rd_done |
| rd_addr | input | 32 | Read address |
| rd_done | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Request address |
| mem_req_data | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables (all ones for reads) |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 32 | Read response data |

## Verification
The bench fills the queue while memory refuses requests, and then checks several things. It checks that a fifth store stalls and that a store arriving in the cycle a drain completes does not; a design that gates the stall on fullness alone would lose a cycle, and one that ignores fullness would overwrite the oldest slot. It checks the request order when a read misses behind three queued writes: a design without read priority would let the later writes out first, and one that withdraws an offered write would break the handshake. It also reads words that are partly covered, and words stored twice into separate slots. A wrong per-byte merge or a wrong age order returns stale or zeroed lanes. A design that folds a store into a slot already offered to memory drops a write, or changes data while the request is held.

// File: rtl/wtb_pkg.sv
// Shared constants and types of the write-through store buffer.
// Assumes a byte-addressed memory with a data word of LANES bytes.
package wtb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int WOFS   = $clog2(LANES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } wtb_entry_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2,
        RD_RESP  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/wtb_queue.sv
// Circular store queue with same-word folding.
// Assumes DEPTH is a power of two. Occupied slots are contiguous from
// the head. The caller never pops an empty queue and never pushes a new
// slot into a full queue unless it also pops in that cycle.
module wtb_queue
    import wtb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  wtb_entry_t             push_ent,
    input  logic                   pop,
    input  logic                   head_locked,
    output wtb_entry_t [DEPTH-1:0] ent_o,
    output logic [DEPTH-1:0]       vld_o,
    output logic [PW-1:0]          head_o,
    output logic [CW-1:0]          count_o,
    output logic                   full_o,
    output logic                   merge_hit_o
);
    wtb_entry_t [DEPTH-1:0] ent_q;
    logic [DEPTH-1:0]       vld_q;
    logic [PW-1:0]          head_q, tail_q, merge_idx;
    logic [CW-1:0]          count_q;

    // Find a slot holding the same word that memory has not yet seen.
    always_comb begin
        merge_hit_o = 1'b0;
        merge_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i] &&
                (ent_q[i].addr[ADDR_W-1:WOFS] == push_ent.addr[ADDR_W-1:WOFS]) &&
                !(head_locked && (PW'(i) == head_q))) begin
                merge_hit_o = 1'b1;
                merge_idx   = PW'(i);
            end
        end
    end

    // Slot storage, pointers and occupancy; a push after a pop wins a shared slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (pop) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= head_q + PW'(1);
            end
            if (push && merge_hit_o) begin
                for (int b = 0; b < LANES; b++) begin
                    if (push_ent.be[b]) begin
                        ent_q[merge_idx].data[8*b +: 8] <= push_ent.data[8*b +: 8];
                    end
                end
                ent_q[merge_idx].be <= ent_q[merge_idx].be | push_ent.be;
            end else if (push) begin
                ent_q[tail_q] <= push_ent;
                vld_q[tail_q] <= 1'b1;
                tail_q        <= tail_q + PW'(1);
            end
            count_q <= count_q + CW'(push && !merge_hit_o) - CW'(pop);
        end
    end

    assign ent_o   = ent_q;
    assign vld_o   = vld_q;
    assign head_o  = head_q;
    assign count_o = count_q;
    assign full_o  = (count_q == CW'(DEPTH));
endmodule

// File: rtl/wtb_fwd.sv
// Per-lane read forwarding from the store queue.
// Walks the slots from oldest to newest so that a newer slot overrides
// an older one lane by lane. Lanes with no match read as zero and are
// flagged clear in the mask.
module wtb_fwd
    import wtb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH)
) (
    input  wtb_entry_t [DEPTH-1:0] ent,
    input  logic [DEPTH-1:0]       vld,
    input  logic [PW-1:0]          head,
    input  logic [ADDR_W-1:WOFS]   rd_word,
    output logic [LANES-1:0]       fwd_mask,
    output logic [DATA_W-1:0]      fwd_data
);
    // Age-ordered scan; the last write to a lane is the newest.
    always_comb begin
        logic [PW-1:0] idx;
        fwd_mask = '0;
        fwd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (vld[idx] && (ent[idx].addr[ADDR_W-1:WOFS] == rd_word)) begin
                for (int b = 0; b < LANES; b++) begin
                    if (ent[idx].be[b]) begin
                        fwd_mask[b]         = 1'b1;
                        fwd_data[8*b +: 8]  = ent[idx].data[8*b +: 8];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wtb_rdctl.sv
// Read-miss sequencer: snapshots the forwarded lanes when a read is
// taken. It answers at once when all lanes are covered, and otherwise
// issues one memory read and fills the remaining lanes from the response.
// Assumes rd_valid and rd_addr are held until rd_done.
module wtb_rdctl
    import wtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [LANES-1:0]  fwd_mask,
    input  logic [DATA_W-1:0] fwd_data,
    input  logic              port_free,
    input  logic              mem_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rd_issue,
    output logic              drain_block,
    output logic              in_issue,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    rd_state_e          state_q;
    logic [LANES-1:0]   mask_q;
    logic [DATA_W-1:0]  data_q;

    // Read state, lane mask and assembled data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            mask_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                RD_IDLE: if (rd_valid) begin
                    mask_q  <= fwd_mask;
                    data_q  <= fwd_data;
                    state_q <= (&fwd_mask) ? RD_RESP : RD_ISSUE;
                end
                RD_ISSUE: if (rd_issue && mem_ready) state_q <= RD_WAIT;
                RD_WAIT: if (rsp_valid) begin
                    for (int b = 0; b < LANES; b++) begin
                        if (!mask_q[b]) data_q[8*b +: 8] <= rsp_data[8*b +: 8];
                    end
                    state_q <= RD_RESP;
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    // Port arbitration hints and the response.
    always_comb begin
        in_issue    = (state_q == RD_ISSUE);
        rd_issue    = in_issue && port_free;
        drain_block = in_issue || ((state_q == RD_IDLE) && rd_valid);
        rd_done     = (state_q == RD_RESP);
        rd_data     = data_q;
    end
endmodule

// File: rtl/wt_store_buffer.sv
// Write-through store buffer with read bypass (top).
// Posts stores into a DEPTH-slot queue and drains them in order over a
// valid/ready port. A read miss is checked lane by lane against the
// queue and is sent ahead of writes that memory has not yet seen. An
// offered write is never withdrawn.
module wt_store_buffer
    import wtb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [LANES-1:0]  st_be,
    output logic              st_stall,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    output logic [LANES-1:0]  mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    wtb_entry_t [DEPTH-1:0] ent;
    wtb_entry_t             st_ent, head_ent;
    logic [DEPTH-1:0]       vld;
    logic [PW-1:0]          head;
    logic [CW-1:0]          q_count;
    logic                   q_full, merge_hit, head_shown_q;
    logic                   wr_present, pop, push, head_locked;
    logic                   rd_issue, drain_block, rd_in_issue;
    logic [LANES-1:0]       fwd_mask;
    logic [DATA_W-1:0]      fwd_data;

    assign st_ent = '{addr: st_addr, data: st_data, be: st_be};

    wtb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .push_ent(st_ent), .pop(pop),
        .head_locked(head_locked), .ent_o(ent), .vld_o(vld), .head_o(head),
        .count_o(q_count), .full_o(q_full), .merge_hit_o(merge_hit)
    );

    wtb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ent(ent), .vld(vld), .head(head), .rd_word(rd_addr[ADDR_W-1:WOFS]),
        .fwd_mask(fwd_mask), .fwd_data(fwd_data)
    );

    wtb_rdctl u_rdctl (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .fwd_mask(fwd_mask),
        .fwd_data(fwd_data), .port_free(!head_shown_q), .mem_ready(mem_req_ready),
        .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .rd_issue(rd_issue),
        .drain_block(drain_block), .in_issue(rd_in_issue), .rd_done(rd_done),
        .rd_data(rd_data)
    );

    // Drain and store acceptance: an offered head is held until taken.
    always_comb begin
        head_ent    = ent[head];
        wr_present  = (q_count != '0) && (head_shown_q || !drain_block);
        pop         = wr_present && mem_req_ready;
        head_locked = head_shown_q || wr_present;
        st_stall    = st_valid && q_full && !merge_hit && !pop;
        push        = st_valid && !st_stall;
    end

    // Remember a head write that was offered but not yet taken.
    always_ff @(posedge clk) begin
        if (!rst_n) head_shown_q <= 1'b0;
        else        head_shown_q <= wr_present && !mem_req_ready;
    end

    // Request port mux: a read and a write are never offered together.
    always_comb begin
        mem_req_valid = rd_issue || wr_present;
        mem_req_write = !rd_issue;
        mem_req_addr  = rd_issue ? rd_addr : head_ent.addr;
        mem_req_data  = head_ent.data;
        mem_req_be    = rd_issue ? '1 : head_ent.be;
    end
endmodule

// File: rtl/wtb_checker.sv
// Protocol and state checks for wt_store_buffer, attached by bind.
// Observes the request port, the store stall, the read pulse and the
// queue occupancy; drives nothing.
module wtb_checker
    import wtb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_stall,
    input logic              rd_done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_data,
    input logic [LANES-1:0]  mem_req_be,
    input logic [CW-1:0]     q_count,
    input logic              rd_in_issue
);
    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_addr) && $stable(mem_req_data) && $stable(mem_req_be)));

    p_stall_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (q_count == CW'(DEPTH)));

    p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req_valid && !rd_done && !st_stall));

    p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_issue && mem_req_valid && mem_req_write) |-> $past(mem_req_valid && mem_req_write));
endmodule

bind wt_store_buffer wtb_checker #(.DEPTH(DEPTH)) u_wtb_checker (
    .clk(clk), .rst_n(rst_n), .st_stall(st_stall), .rd_done(rd_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
    .q_count(q_count), .rd_in_issue(rd_in_issue)
);

// File: tb/wt_store_buffer_test.sv
`timescale 1ns/1ps
module wt_store_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_stall;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_done;
    logic [31:0] rd_data;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_data;
    logic [3:0]  mem_req_be;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    typedef struct {
        bit          wr;
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        string       tag;
    } exp_t;
    exp_t exq[$];

    logic [31:0] mem [logic [29:0]];
    bit          rsp_pend = 0;
    logic [31:0] rsp_d = '0;

    always #10 clk = ~clk;

    wt_store_buffer uut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return mem.exists(a[31:2]) ? mem[a[31:2]] : 32'h0;
    endfunction

    task automatic expect_w(input logic [31:0] a, d, input logic [3:0] be, input string tag);
        exp_t e;
        e.wr = 1; e.a = a; e.d = d; e.be = be; e.tag = tag;
        exq.push_back(e);
    endtask

    task automatic expect_r(input logic [31:0] a, input string tag);
        exp_t e;
        e.wr = 0; e.a = a; e.d = '0; e.be = 4'hF; e.tag = tag;
        exq.push_back(e);
    endtask

    // Monitor and memory model: drive responses at negedge, observe 2 ns before posedge.
    always begin
        @(negedge clk);
        mem_rsp_valid = rsp_pend;
        mem_rsp_data  = rsp_d;
        rsp_pend      = 0;
        #8;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (exq.size() == 0) begin
                chk(0, "R1", "unexpected request addr", mem_req_addr, 32'h0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk(mem_req_write == e.wr, e.tag, "request kind", 32'(mem_req_write), 32'(e.wr));
                chk(mem_req_addr == e.a, e.tag, "request addr", mem_req_addr, e.a);
                chk(mem_req_be == e.be, e.tag, "request enables", 32'(mem_req_be), 32'(e.be));
                if (e.wr) chk(mem_req_data == e.d, e.tag, "write data", mem_req_data, e.d);
            end
            if (mem_req_write) begin
                logic [31:0] w;
                w = rdmem(mem_req_addr);
                for (int b = 0; b < 4; b++)
                    if (mem_req_be[b]) w[8*b +: 8] = mem_req_data[8*b +: 8];
                mem[mem_req_addr[31:2]] = w;
            end else begin
                rsp_pend = 1;
                rsp_d    = rdmem(mem_req_addr);
            end
        end
    end

    task automatic store(input logic [31:0] a, d, input logic [3:0] be);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_data = d; st_be = be;
        for (int i = 0; i < 100; i++) begin
            #8;
            if (!st_stall) break;
            if (i == 99) chk(0, "R2", "store never accepted", 32'(st_stall), 32'h0);
            @(negedge clk);
        end
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic read_check(input logic [31:0] a, exp, input string tag, output int waited);
        bit got;
        got = 0;
        waited = 0;
        @(negedge clk);
        rd_valid = 1; rd_addr = a;
        for (int i = 0; i < 200; i++) begin
            #8;
            if (rd_done) begin got = 1; break; end
            @(negedge clk);
            waited++;
        end
        chk(got, tag, "read completed", 32'(got), 32'h1);
        chk(rd_data == exp, tag, "read data", rd_data, exp);
        @(negedge clk);
        rd_valid = 0;
        #8;
        chk(!rd_done, "R11", "done is one cycle", 32'(rd_done), 32'h0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int w;
        idle(3);
        #8;
        chk(!mem_req_valid, "R10", "no request in reset", 32'(mem_req_valid), 32'h0);
        chk(!rd_done, "R10", "rd_done low in reset", 32'(rd_done), 32'h0);
        chk(!st_stall, "R10", "stall low in reset", 32'(st_stall), 32'h0);
        @(negedge clk); rst_n = 1;

        // R1/R9: in-order drain while memory first refuses
        expect_w(32'h100, 32'hA1, 4'hF, "R1");
        expect_w(32'h104, 32'hA2, 4'h3, "R1");
        expect_w(32'h108, 32'hA3, 4'hC, "R1");
        store(32'h100, 32'hA1, 4'hF);
        store(32'h104, 32'hA2, 4'h3);
        store(32'h108, 32'hA3, 4'hC);
        #8;
        chk(mem_req_valid && mem_req_write, "R9", "head offered", 32'(mem_req_valid), 32'h1);
        chk(mem_req_addr == 32'h100, "R9", "held addr", mem_req_addr, 32'h100);
        idle(3); #8;
        chk(mem_req_addr == 32'h100 && mem_req_data == 32'hA1, "R9", "still held", mem_req_addr, 32'h100);
        @(negedge clk); mem_req_ready = 1;
        idle(6);
        chk(exq.size() == 0, "R1", "all writes drained", 32'(exq.size()), 32'h0);

        // R8: folding into an unoffered slot
        mem_req_ready = 0;
        expect_w(32'h200, 32'h11111111, 4'hF, "R8");
        expect_w(32'h204, 32'hDDEEBBCC, 4'hF, "R8");
        expect_w(32'h208, 32'h55, 4'hF, "R8");
        store(32'h200, 32'h11111111, 4'hF);
        store(32'h204, 32'h0000BBCC, 4'h3);
        store(32'h208, 32'h55, 4'hF);
        store(32'h204, 32'hDDEE0000, 4'hC);
        @(negedge clk); mem_req_ready = 1;
        idle(6);
        chk(exq.size() == 0, "R8", "merged write count", 32'(exq.size()), 32'h0);

        // R2/R3: full queue stalls, drain in same cycle releases
        mem_req_ready = 0;
        for (int i = 0; i < 5; i++)
            expect_w(32'h300 + 32'(4*i), 32'h31 + 32'(i), 4'hF, (i == 4) ? "R3" : "R2");
        for (int i = 0; i < 4; i++)
            store(32'h300 + 32'(4*i), 32'h31 + 32'(i), 4'hF);
        @(negedge clk);
        st_valid = 1; st_addr = 32'h310; st_data = 32'h35; st_be = 4'hF;
        #8; chk(st_stall, "R2", "stall when full", 32'(st_stall), 32'h1);
        @(negedge clk); #8; chk(st_stall, "R2", "stall held", 32'(st_stall), 32'h1);
        @(negedge clk); mem_req_ready = 1;
        #8; chk(!st_stall, "R3", "no stall with drain", 32'(st_stall), 32'h0);
        @(negedge clk); st_valid = 0;
        idle(8); #8;
        chk(!mem_req_valid, "R2", "queue emptied", 32'(mem_req_valid), 32'h0);
        chk(exq.size() == 0, "R3", "five writes seen", 32'(exq.size()), 32'h0);

        // R5: fully covered read answered locally
        @(negedge clk); mem_req_ready = 0;
        expect_w(32'h400, 32'hCAFEF00D, 4'hF, "R5");
        store(32'h400, 32'hCAFEF00D, 4'hF);
        read_check(32'h400, 32'hCAFEF00D, "R5", w);
        chk(w == 1, "R5", "hit latency", 32'(w), 32'h1);
        @(negedge clk); mem_req_ready = 1;
        idle(4);

        // R6: two slots for one word, newest wins
        mem_req_ready = 0;
        expect_w(32'h500, 32'h11111111, 4'hF, "R6");
        expect_w(32'h500, 32'h22222222, 4'hF, "R6");
        store(32'h500, 32'h11111111, 4'hF);
        store(32'h500, 32'h22222222, 4'hF);
        read_check(32'h500, 32'h22222222, "R6", w);
        @(negedge clk); mem_req_ready = 1;
        idle(5);

        // R4/R7: partial hit behind queued writes
        expect_w(32'h600, 32'h11223344, 4'hF, "R7");
        store(32'h600, 32'h11223344, 4'hF);
        idle(3);
        mem_req_ready = 0;
        expect_w(32'h700, 32'h77, 4'hF, "R4");
        expect_r(32'h600, "R4");
        expect_w(32'h600, 32'hAA, 4'h1, "R4");
        expect_w(32'h604, 32'h66, 4'hF, "R4");
        store(32'h700, 32'h77, 4'hF);
        store(32'h600, 32'hAA, 4'h1);
        store(32'h604, 32'h66, 4'hF);
        fork
            read_check(32'h600, 32'h112233AA, "R7", w);
            begin idle(3); mem_req_ready = 1; end
        join
        idle(5);
        chk(exq.size() == 0, "R4", "read ahead of writes", 32'(exq.size()), 32'h0);

        // R10: reset discards queued slots
        mem_req_ready = 0;
        store(32'h800, 32'h88, 4'hF);
        store(32'h804, 32'h89, 4'hF);
        @(negedge clk); rst_n = 0;
        idle(2);
        rst_n = 1;
        #8;
        chk(!mem_req_valid, "R10", "no request after reset", 32'(mem_req_valid), 32'h0);
        @(negedge clk); mem_req_ready = 1;
        idle(5);
        expect_r(32'h800, "R10");
        read_check(32'h800, 32'h0, "R10", w);
        idle(3);
        chk(exq.size() == 0, "R10", "scoreboard empty", 32'(exq.size()), 32'h0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule